// File: doc/BRIEF.md
# Byte/Word Switchable ROM Read Port

This block models the read side of a read-only memory that can present either a 16-bit word or a single byte. It is clocked for simulation and has one register stage, which stands in for the access time. A mode input selects the width. In wide mode the full word at the given word address is driven out on both byte lanes. In narrow mode an extra low-order address bit picks one of the two halves of that word. The chosen half is always returned on the lower lane, and the upper lane is released.

Each lane has its own enable output, which models a three-state driver: a lane whose enable is low is floating. The top lane also covers data bit 15, and in narrow mode that same pin serves as the low address bit. Chip enable and output enable are both active low, and either one inactive releases both lanes. The contents come from a fixed arithmetic formula of the word address, so no external data is needed. The depth is a parameter, and the port keeps no state from one read to the next.

Top module: `rom_port`

## Requirements
- R1: While rst_n is low, and in the first sampled cycle after it rises, lane_en is 2'b00 and data_q is 16'h0000.
- R2: When ce_n is high at a rising clock edge, lane_en is 2'b00 and data_q is 16'h0000 after that edge (standby, both lanes floating).
- R3: When ce_n is low and oe_n is high at an edge, lane_en is 2'b00 and data_q is 16'h0000 after that edge.
- R4: When ce_n and oe_n are both low and wide_mode is 1 at an edge, lane_en becomes 2'b11 after that edge, and data_q becomes the word at word_addr. The word at address a is hi*256+lo, where lo=(13a+1) mod 256 and hi=((7a+3) mod 256) XOR 8'h5A.
- R5: When ce_n and oe_n are both low, wide_mode is 0 and a_lsb is 0 at an edge, lane_en becomes 2'b01 after that edge, and data_q[7:0] becomes the low byte of the word at word_addr.
- R6: When ce_n and oe_n are both low, wide_mode is 0 and a_lsb is 1 at an edge, lane_en becomes 2'b01 after that edge, and data_q[7:0] becomes the high byte of the word at word_addr.
- R7: In narrow mode (wide_mode 0), the upper lane floats (lane_en[1] is 0) and data_q[15:8] is 8'h00.
- R8: In wide mode, a_lsb has no effect: data_q is the same for a_lsb 0 and 1.
- R9: A change of wide_mode takes effect on the very next edge, with no reads carried over from earlier cycles.
- R10: Reads are correct at both ends of the array, word address 0 and word address DEPTH-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Simulation clock; inputs are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| wide_mode | input | 1 | 1 = 16-bit word reads, 0 = 8-bit byte reads |
| a_lsb | input | 1 | Byte select (half of the word) in narrow mode; ignored in wide mode |
| word_addr | input | AW | Word address, AW = log2(DEPTH) |
| data_q | output | 16 | Read data; bits of a floating lane are zero |
| lane_en | output | 2 | Lane drive enables: bit 0 covers bits 7:0, bit 1 covers bits 15:8 |

## Verification
Every result is due exactly one rising edge after the inputs that cause it, because a single register stage sits between the inputs and data_q and lane_en. The bench changes inputs on the falling edge, waits for one rising edge, and samples on the following falling edge. At that point the design has updated once and the inputs are not yet changing. The mode-flip scenario alternates wide_mode on consecutive edges and checks each sample against the current cycle's mode alone, which shows that no older read leaks forward.

// File: rtl/rom_port_pkg.sv
package rom_port_pkg;

  typedef enum logic {
    MODE_BYTE = 1'b0,
    MODE_WORD = 1'b1
  } port_mode_e;

  localparam int unsigned LANE_W  = 8;
  localparam int unsigned LANES   = 2;
  localparam int unsigned WORD_W  = LANE_W * LANES;

  // Fixed content formula: low lane and high lane derived from the address.
  function automatic logic [WORD_W-1:0] cell_word(input int unsigned a);
    logic [LANE_W-1:0] lo;
    logic [LANE_W-1:0] hi;
    lo = LANE_W'(a * 13 + 1);
    hi = LANE_W'(a * 7 + 3) ^ 8'h5A;
    return {hi, lo};
  endfunction

endpackage

// File: rtl/rom_cells.sv
module rom_cells
  import rom_port_pkg::*;
#(
  parameter int unsigned DEPTH = 256,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic [AW-1:0]     rd_addr,
  output logic [WORD_W-1:0] rd_word
);

  logic [WORD_W-1:0] cells [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_cell
    assign cells[g] = cell_word(g);
  end

  assign rd_word = cells[rd_addr];

endmodule

// File: rtl/rom_lane_steer.sv
module rom_lane_steer
  import rom_port_pkg::*;
(
  input  logic              wide_mode,
  input  logic              a_lsb,
  input  logic [WORD_W-1:0] word_in,
  output logic [WORD_W-1:0] lanes_out
);

  port_mode_e mode;
  logic [LANE_W-1:0] half;

  assign mode = port_mode_e'(wide_mode);
  assign half = a_lsb ? word_in[WORD_W-1:LANE_W] : word_in[LANE_W-1:0];

  always_comb begin
    unique case (mode)
      MODE_WORD: lanes_out = word_in;
      default:   lanes_out = {{LANE_W{1'b0}}, half};
    endcase
  end

endmodule

// File: rtl/rom_oe_decode.sv
module rom_oe_decode
  import rom_port_pkg::*;
(
  input  logic             ce_n,
  input  logic             oe_n,
  input  logic             wide_mode,
  output logic [LANES-1:0] lane_drive
);

  logic reading;

  assign reading = !ce_n && !oe_n;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    if (l == 0) begin : g_low
      assign lane_drive[l] = reading;
    end else begin : g_up
      assign lane_drive[l] = reading && wide_mode;
    end
  end

endmodule

// File: rtl/rom_port.sv
module rom_port
  import rom_port_pkg::*;
#(
  parameter int unsigned DEPTH = 256,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              wide_mode,
  input  logic              a_lsb,
  input  logic [AW-1:0]     word_addr,
  output logic [WORD_W-1:0] data_q,
  output logic [LANES-1:0]  lane_en
);

  logic [WORD_W-1:0] cell_rd;
  logic [WORD_W-1:0] steered;
  logic [LANES-1:0]  drive_nx;
  logic [WORD_W-1:0] lane_mask;

  rom_cells #(.DEPTH(DEPTH)) u_cells (
    .rd_addr (word_addr),
    .rd_word (cell_rd)
  );

  rom_lane_steer u_steer (
    .wide_mode (wide_mode),
    .a_lsb     (a_lsb),
    .word_in   (cell_rd),
    .lanes_out (steered)
  );

  rom_oe_decode u_oe (
    .ce_n       (ce_n),
    .oe_n       (oe_n),
    .wide_mode  (wide_mode),
    .lane_drive (drive_nx)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_mask
    assign lane_mask[l*LANE_W +: LANE_W] = {LANE_W{drive_nx[l]}};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q  <= '0;
      lane_en <= '0;
    end else begin
      data_q  <= steered & lane_mask;
      lane_en <= drive_nx;
    end
  end

endmodule

// File: rtl/rom_port_chk.sv
module rom_port_chk
  import rom_port_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              ce_n,
  input logic              oe_n,
  input logic              wide_mode,
  input logic              a_lsb,
  input logic [WORD_W-1:0] cell_rd,
  input logic [WORD_W-1:0] data_q,
  input logic [LANES-1:0]  lane_en
);

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    !rst_n |=> (lane_en == 2'b00 && data_q == 16'h0000));

  // R2
  standby_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |=> (lane_en == 2'b00 && data_q == 16'h0000));

  // R3
  oe_off_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && oe_n) |=> (lane_en == 2'b00 && data_q == 16'h0000));

  // R4 R8
  word_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && !oe_n && wide_mode) |=> (lane_en == 2'b11 && data_q == $past(cell_rd)));

  // R5
  byte_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && !oe_n && !wide_mode && !a_lsb)
      |=> (lane_en == 2'b01 && data_q[7:0] == $past(cell_rd[7:0])));

  // R6
  byte_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && !oe_n && !wide_mode && a_lsb)
      |=> (lane_en == 2'b01 && data_q[7:0] == $past(cell_rd[15:8])));

  // R7
  upper_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wide_mode |=> (!lane_en[1] && data_q[15:8] == 8'h00));

endmodule

bind rom_port rom_port_chk u_rom_port_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ce_n      (ce_n),
  .oe_n      (oe_n),
  .wide_mode (wide_mode),
  .a_lsb     (a_lsb),
  .cell_rd   (cell_rd),
  .data_q    (data_q),
  .lane_en   (lane_en)
);

// File: tb/test_rom_port.sv
module test_rom_port;

  localparam time CLK_PERIOD = 10ns;
  localparam int  DEPTH      = 256;
  localparam int  AW         = $clog2(DEPTH);
  localparam int  WATCHDOG   = 20000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ce_n = 1'b1;
  logic          oe_n = 1'b1;
  logic          wide_mode = 1'b1;
  logic          a_lsb = 1'b0;
  logic [AW-1:0] word_addr = '0;
  logic [15:0]   data_q;
  logic [1:0]    lane_en;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rom_port #(.DEPTH(DEPTH)) i_rom_port (
    .clk       (clk),
    .rst_n     (rst_n),
    .ce_n      (ce_n),
    .oe_n      (oe_n),
    .wide_mode (wide_mode),
    .a_lsb     (a_lsb),
    .word_addr (word_addr),
    .data_q    (data_q),
    .lane_en   (lane_en)
  );

  // Bench restatement of the content formula, written with modulo arithmetic.
  function automatic int exp_lo(input int a);
    return (a * 13 + 1) % 256;
  endfunction

  function automatic int exp_hi(input int a);
    return ((a * 7 + 3) % 256) ^ 90;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // Drive at the falling edge, let one rising edge register it, sample on the next falling edge.
  task automatic cycle(input bit ce, input bit oe, input bit wide, input bit lsb, input int addr);
    ce_n      = ce;
    oe_n      = oe;
    wide_mode = wide;
    a_lsb     = lsb;
    word_addr = AW'(addr);
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1 lanes in reset", int'(lane_en), 0);
    check("R1 data in reset", int'(data_q), 0);
    rst_n = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R1 lanes after release (ce_n high)", int'(lane_en), 0);
    check("R1 data after release", int'(data_q), 0);
  endtask

  task automatic t_standby();
    cycle(1'b0, 1'b0, 1'b1, 1'b0, 9);
    cycle(1'b1, 1'b0, 1'b1, 1'b0, 9);
    check("R2 standby lanes", int'(lane_en), 0);
    check("R2 standby data", int'(data_q), 0);
    cycle(1'b1, 1'b1, 1'b0, 1'b1, 40);
    check("R2 standby lanes byte mode", int'(lane_en), 0);
  endtask

  task automatic t_output_off();
    cycle(1'b0, 1'b1, 1'b1, 1'b0, 17);
    check("R3 oe off lanes", int'(lane_en), 0);
    check("R3 oe off data", int'(data_q), 0);
    cycle(1'b0, 1'b1, 1'b0, 1'b1, 17);
    check("R3 oe off lanes byte mode", int'(lane_en), 0);
  endtask

  task automatic t_word_reads();
    int addrs[4] = '{3, 77, 128, 200};
    foreach (addrs[i]) begin
      cycle(1'b0, 1'b0, 1'b1, 1'b0, addrs[i]);
      check("R4 word lanes", int'(lane_en), 3);
      check("R4 word data", int'(data_q), exp_hi(addrs[i]) * 256 + exp_lo(addrs[i]));
    end
  endtask

  task automatic t_byte_low();
    for (int a = 10; a < 14; a++) begin
      cycle(1'b0, 1'b0, 1'b0, 1'b0, a);
      check("R5 byte low lanes", int'(lane_en), 1);
      check("R5 byte low data", int'(data_q[7:0]), exp_lo(a));
      check("R7 upper lane zero (low half)", int'(data_q[15:8]), 0);
    end
  endtask

  task automatic t_byte_high();
    for (int a = 50; a < 54; a++) begin
      cycle(1'b0, 1'b0, 1'b0, 1'b1, a);
      check("R6 byte high lanes", int'(lane_en), 1);
      check("R6 byte high data", int'(data_q[7:0]), exp_hi(a));
      check("R7 upper lane floating", int'(lane_en[1]), 0);
      check("R7 upper lane zero (high half)", int'(data_q[15:8]), 0);
    end
  endtask

  task automatic t_word_ignores_lsb();
    int a = 99;
    int exp_w = exp_hi(99) * 256 + exp_lo(99);
    cycle(1'b0, 1'b0, 1'b1, 1'b0, a);
    check("R8 word data lsb 0", int'(data_q), exp_w);
    cycle(1'b0, 1'b0, 1'b1, 1'b1, a);
    check("R8 word data lsb 1", int'(data_q), exp_w);
    check("R8 lanes lsb 1", int'(lane_en), 3);
  endtask

  task automatic t_mode_flip();
    int a = 33;
    cycle(1'b0, 1'b0, 1'b1, 1'b1, a);
    check("R9 word before flip", int'(data_q), exp_hi(a) * 256 + exp_lo(a));
    cycle(1'b0, 1'b0, 1'b0, 1'b1, a);
    check("R9 byte right after flip", int'(data_q), exp_hi(a));
    check("R9 lanes right after flip", int'(lane_en), 1);
    cycle(1'b0, 1'b0, 1'b1, 1'b0, a + 1);
    check("R9 word right after flip back", int'(data_q), exp_hi(a + 1) * 256 + exp_lo(a + 1));
    check("R9 lanes after flip back", int'(lane_en), 3);
  endtask

  task automatic t_edges();
    cycle(1'b0, 1'b0, 1'b1, 1'b0, 0);
    check("R10 word at address 0", int'(data_q), exp_hi(0) * 256 + exp_lo(0));
    cycle(1'b0, 1'b0, 1'b1, 1'b0, DEPTH - 1);
    check("R10 word at last address", int'(data_q), exp_hi(DEPTH - 1) * 256 + exp_lo(DEPTH - 1));
    cycle(1'b0, 1'b0, 1'b0, 1'b1, DEPTH - 1);
    check("R10 high byte at last address", int'(data_q), exp_hi(DEPTH - 1));
    cycle(1'b0, 1'b0, 1'b0, 1'b0, 0);
    check("R10 low byte at address 0", int'(data_q), exp_lo(0));
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  endtask

  initial begin
    for (int c = 0; c < WATCHDOG; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    t_reset();
    t_standby();
    t_output_off();
    t_word_reads();
    t_byte_low();
    t_byte_high();
    t_word_ignores_lsb();
    t_mode_flip();
    t_edges();
    done = 1'b1;
    finish_run();
  end

endmodule